// File: doc/BRIEF.md
# Index-Addressed Particle Propagation Controller

This block runs the sampling step of a particle filter for one state dimension. It keeps a single particle memory of depth M, and there is no separate store for resampled particles. Resampling hands the block an index array. Entry k of that array names the stored particle that output particle k descends from. The block fetches each referenced particle by pointer and passes it through a fixed-latency propagation datapath. It then writes the propagated value back into the same memory. In this project the datapath is a random-walk stub that adds a deterministic noise term. A filter with several state dimensions uses one instance per dimension, all driven with the same index array.

Writing the result of particle k straight to address k could destroy a particle that a later index still points to. The controller prevents this with a reference count per address. The counts are built while the index array is loaded, and each fetch decrements the count of the address it reads. Every result goes to the lowest address that no pending fetch still needs and that has not yet been filled in the current pass. Because of this rule a pass never stalls, whatever the index pattern. One parameter selects between a dual-port memory, which reads and writes in the same cycle, and a single-port memory, in which each particle is read, propagated and written before the next read is issued.

Top module: `particle_prop_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are low.
- R2: Result k equals x[ind(k)] + (k·NOISE_MUL + NOISE_ADD) mod 2^DW, where x is the memory content at the start of the pass and ind(k) is index entry k.
- R3: Results are written in order k = 0..M-1. Result k goes to the lowest address that has not yet been filled in this pass and that is not named by any index entry j > k + LAG, where LAG is LS with the dual-port memory and 0 with the single-port memory.
- R4: With DUAL=1, `done` rises exactly M + LS + 3 clock edges after the edge that samples `start` while idle. This holds for every index pattern.
- R5: With DUAL=0, `done` rises exactly M·(LS+3) + 1 edges after the sampling edge, and no memory write happens in a cycle that carries a memory read.
- R6: `done` is high for exactly one cycle per pass. A `start` raised while `busy` is high has no effect on the pass timing or on its result.
- R7: While idle, `init_we` writes `init_data` at `init_addr`, and `rd_data` shows the word at `rd_addr` one clock edge after that address is sampled.
- R8: Index entries are loaded while idle, and each entry is written once per pass. The reference counts return to zero by the end of every pass, so passes can be repeated with fresh index arrays and need no clearing step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_we | input | 1 | Particle write strobe while idle |
| init_addr | input | $clog2(M) | Particle write address |
| init_data | input | DW | Particle write value |
| idx_we | input | 1 | Index entry write strobe while idle |
| idx_addr | input | $clog2(M) | Index entry position k |
| idx_data | input | $clog2(M) | Particle address referenced by entry k |
| start | input | 1 | Begins a pass when idle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pass completion pulse |
| rd_addr | input | $clog2(M) | Readout address while idle |
| rd_data | output | DW | Registered readout data |

## Verification
The bench sweeps index patterns that stress overwrite hazards. These include every entry naming address 0, every entry naming the last address, a reversed mapping, sorted runs of the kind systematic resampling produces, and scrambled arrays. Each pattern runs on a dual-port and a single-port instance side by side. A controller that wrote result k at address k would corrupt later fetches in the reversed and all-zero cases and return wrong values. An allocator that ignored pending references would fail in the same cases. An allocator that picked some other free slot would leave the right values at the wrong addresses. A pipeline with an extra or a missing register would shift the `done` timing. A `start` pulse raised in the middle of one pass checks that the pass cannot be restarted.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // Deterministic stand-in for process noise: affine in the particle sequence number.
  function automatic logic [31:0] noise_term(input logic [31:0] seq,
                                             input logic [31:0] mul,
                                             input logic [31:0] add);
    return seq * mul + add;
  endfunction

endpackage

// File: rtl/ppc_pmem.sv
module ppc_pmem #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  parameter int DUAL  = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  generate
    if (DUAL != 0) begin : g_two_port
      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
      end
    end else begin : g_one_port
      logic [AW-1:0] port_addr;
      assign port_addr = we ? waddr : raddr;
      always_ff @(posedge clk) begin
        if (we) mem[port_addr] <= wdata;
        else    rdata <= mem[port_addr];
      end
    end
  endgenerate

endmodule

// File: rtl/ppc_slot_alloc.sv
module ppc_slot_alloc #(
  parameter int M  = 64,
  localparam int AW = $clog2(M),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_en,
  input  logic [AW-1:0] inc_addr,
  input  logic          dec_en,
  input  logic [AW-1:0] dec_addr,
  input  logic          clr_fill,
  input  logic          alloc,
  output logic [AW-1:0] dest,
  output logic          free_any
);

  logic [CW-1:0] refs [M];
  logic [M-1:0]  filled;
  logic [M-1:0]  free_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < M; a++) refs[a] <= '0;
      filled <= '0;
    end else begin
      if (inc_en) refs[inc_addr] <= refs[inc_addr] + 1'b1;
      if (dec_en) refs[dec_addr] <= refs[dec_addr] - 1'b1;
      if (clr_fill)   filled <= '0;
      else if (alloc) filled[dest] <= 1'b1;
    end
  end

  always_comb begin
    for (int a = 0; a < M; a++) free_vec[a] = (refs[a] == '0) && !filled[a];
  end

  // Lowest free address wins.
  always_comb begin
    dest = '0;
    for (int a = M - 1; a >= 0; a--) begin
      if (free_vec[a]) dest = AW'(a);
    end
  end

  assign free_any = |free_vec;

  AST_NO_REF_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec_en |-> refs[dec_addr] != '0); // R8
  AST_FETCH_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    dec_en |-> !filled[dec_addr]); // R2
  AST_SLOT_AVAILABLE: assert property (@(posedge clk) disable iff (rst)
    alloc |-> free_any); // R3

endmodule

// File: rtl/ppc_prop_stub.sv
module ppc_prop_stub #(
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int LS   = 3,
  parameter int NMUL = 40503,
  parameter int NADD = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [AW-1:0] in_seq,
  input  logic [DW-1:0] in_x,
  output logic          out_vld,
  output logic [DW-1:0] out_x
);

  logic [DW-1:0] sum;
  logic [LS-1:0] vld;
  logic [DW-1:0] dat [LS];

  assign sum = in_x + DW'(ppc_pkg::noise_term(32'(in_seq), 32'(NMUL), 32'(NADD)));

  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= in_vld;
    dat[0] <= sum;
  end

  generate
    for (genvar s = 1; s < LS; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) vld[s] <= 1'b0;
        else     vld[s] <= vld[s-1];
        dat[s] <= dat[s-1];
      end
    end
  endgenerate

  assign out_vld = vld[LS-1];
  assign out_x   = dat[LS-1];

endmodule

// File: rtl/particle_prop_ctrl.sv
module particle_prop_ctrl
  import ppc_pkg::*;
#(
  parameter int M         = 64,
  parameter int DW        = 16,
  parameter int LS        = 3,
  parameter int DUAL      = 1,
  parameter int NOISE_MUL = 40503,
  parameter int NOISE_ADD = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init_we,
  input  logic [$clog2(M)-1:0] init_addr,
  input  logic [DW-1:0]        init_data,
  input  logic                 idx_we,
  input  logic [$clog2(M)-1:0] idx_addr,
  input  logic [$clog2(M)-1:0] idx_data,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic [$clog2(M)-1:0] rd_addr,
  output logic [DW-1:0]        rd_data
);

  localparam int AW = $clog2(M);
  localparam int CW = AW + 1;
  localparam int OW = $clog2(M + LS + 4) + 1;

  phase_e        phase;
  logic [CW-1:0] iss;
  logic [OW-1:0] outst;
  logic          issue, start_acc, idle;

  logic [AW-1:0] idx_mem [M];
  logic [AW-1:0] idx_q;
  logic          v1, v2;
  logic [AW-1:0] seq1, seq2;

  logic          wv;
  logic [DW-1:0] wx;
  logic [AW-1:0] dest;
  logic          free_any;

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  assign idle      = (phase == PH_IDLE);
  assign busy      = (phase == PH_RUN);
  assign start_acc = start && idle;
  assign issue     = busy && (iss < CW'(M)) && ((DUAL != 0) || (outst == '0));

  // Index array: written while idle, read once per issued particle.
  always_ff @(posedge clk) begin
    if (idx_we && idle) idx_mem[idx_addr] <= idx_data;
    if (issue)          idx_q <= idx_mem[iss[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      iss   <= '0;
      outst <= '0;
      v1    <= 1'b0;
      v2    <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      v1   <= issue;
      v2   <= v1;
      if (start_acc) begin
        phase <= PH_RUN;
        iss   <= '0;
      end else if (busy) begin
        if (issue) iss <= iss + 1'b1;
        if ((iss == CW'(M)) && (outst == '0)) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
      end
      case ({issue, wv})
        2'b10:   outst <= outst + 1'b1;
        2'b01:   outst <= outst - 1'b1;
        default: outst <= outst;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    seq1 <= iss[AW-1:0];
    seq2 <= seq1;
  end

  assign mem_we    = busy ? wv   : init_we;
  assign mem_waddr = busy ? dest : init_addr;
  assign mem_wdata = busy ? wx   : init_data;
  assign mem_raddr = busy ? idx_q : rd_addr;
  assign rd_data   = mem_rdata;

  ppc_pmem #(.DEPTH(M), .DW(DW), .DUAL(DUAL)) u_pmem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  ppc_slot_alloc #(.M(M)) u_alloc (
    .clk      (clk),
    .rst      (rst),
    .inc_en   (idx_we && idle),
    .inc_addr (idx_data),
    .dec_en   (v1),
    .dec_addr (idx_q),
    .clr_fill (start_acc),
    .alloc    (wv),
    .dest     (dest),
    .free_any (free_any)
  );

  ppc_prop_stub #(.DW(DW), .AW(AW), .LS(LS), .NMUL(NOISE_MUL), .NADD(NOISE_ADD)) u_prop (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (v2),
    .in_seq  (seq2),
    .in_x    (mem_rdata),
    .out_vld (wv),
    .out_x   (wx)
  );

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    done |-> (outst == '0) && !v1 && !v2); // R4
  AST_SP_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    ((DUAL == 0) && wv) |-> !v1); // R5
  AST_WRITE_WHEN_RUN: assert property (@(posedge clk) disable iff (rst)
    wv |-> busy && free_any); // R3

endmodule

// File: tb/particle_prop_ctrl_tb.sv
`timescale 1ns/1ps
module particle_prop_ctrl_tb;
  localparam int M = 8, DW = 8, LS = 2, NM = 37, NA = 5, AW = 3;
  localparam int T_DUAL = M + LS + 3;
  localparam int T_SING = M * (LS + 3) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic init_we = 1'b0, idx_we = 1'b0, start = 1'b0;
  logic [AW-1:0] init_addr = '0, idx_addr = '0, idx_data = '0, rd_addr = '0;
  logic [DW-1:0] init_data = '0;
  logic busy_d, done_d, busy_s, done_s;
  logic [DW-1:0] rd_d, rd_s;

  always #2.5 clk = ~clk;

  particle_prop_ctrl #(.M(M), .DW(DW), .LS(LS), .DUAL(1), .NOISE_MUL(NM), .NOISE_ADD(NA)) u_dut (
    .clk(clk), .rst(rst), .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .idx_we(idx_we), .idx_addr(idx_addr), .idx_data(idx_data), .start(start),
    .busy(busy_d), .done(done_d), .rd_addr(rd_addr), .rd_data(rd_d));

  particle_prop_ctrl #(.M(M), .DW(DW), .LS(LS), .DUAL(0), .NOISE_MUL(NM), .NOISE_ADD(NA)) u_dut_sp (
    .clk(clk), .rst(rst), .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .idx_we(idx_we), .idx_addr(idx_addr), .idx_data(idx_data), .start(start),
    .busy(busy_s), .done(done_s), .rd_addr(rd_addr), .rd_data(rd_s));

  int n_tests = 0, n_fail = 0;
  int ind [M];
  int mdl [2][M];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_init(input int seed);
    for (int a = 0; a < M; a++) begin
      @(negedge clk);
      init_we = 1'b1; init_addr = AW'(a); init_data = DW'(a * 29 + seed);
      mdl[0][a] = (a * 29 + seed) & 255;
      mdl[1][a] = (a * 29 + seed) & 255;
    end
    @(negedge clk); init_we = 1'b0;
  endtask

  // Expected contents per R2 and R3; lag is LS for dual-port, 0 for single-port.
  task automatic predict(input int md, input int lag);
    int pre [M];
    bit filled [M];
    for (int a = 0; a < M; a++) begin pre[a] = mdl[md][a]; filled[a] = 1'b0; end
    for (int k = 0; k < M; k++) begin
      int val, pick;
      val  = (pre[ind[k]] + k * NM + NA) & 255;
      pick = -1;
      for (int a = 0; a < M && pick < 0; a++) begin
        bit pending;
        pending = 1'b0;
        for (int j = k + lag + 1; j < M; j++) if (ind[j] == a) pending = 1'b1;
        if (!filled[a] && !pending) pick = a;
      end
      if (pick >= 0) begin mdl[md][pick] = val; filled[pick] = 1'b1; end
    end
  endtask

  task automatic run_pass(input bit repulse);
    int td, ts, nd, ns;
    for (int k = 0; k < M; k++) begin
      @(negedge clk);
      idx_we = 1'b1; idx_addr = AW'(k); idx_data = AW'(ind[k]);
    end
    @(negedge clk); idx_we = 1'b0;
    predict(0, LS);
    predict(1, 0);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    td = 0; ts = 0; nd = 0; ns = 0;
    for (int cyc = 1; cyc <= 100; cyc++) begin
      @(posedge clk); #1;
      if (repulse && cyc == 3) start = 1'b1;  // R6: start while busy
      if (repulse && cyc == 4) start = 1'b0;
      if (done_d) begin nd++; if (td == 0) td = cyc; end
      if (done_s) begin ns++; if (ts == 0) ts = cyc; end
    end
    chk(td == T_DUAL, "R4 dual done latency", td, T_DUAL);
    chk(ts == T_SING, "R5 single done latency", ts, T_SING);
    chk(nd == 1, "R6 dual done pulses", nd, 1);
    chk(ns == 1, "R6 single done pulses", ns, 1);
    // R8: passes after the first rely on reference counts returning to zero.
    for (int a = 0; a < M; a++) begin
      @(negedge clk); rd_addr = AW'(a);
      @(posedge clk); #1;
      chk(int'(rd_d) == mdl[0][a], "R2 R3 R7 dual memory word", int'(rd_d), mdl[0][a]);
      chk(int'(rd_s) == mdl[1][a], "R2 R3 R7 single memory word", int'(rd_s), mdl[1][a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(!busy_d && !busy_s, "R1 busy after reset", int'(busy_d) + int'(busy_s), 0);
    chk(!done_d && !done_s, "R1 done after reset", int'(done_d) + int'(done_s), 0);
    load_init(11);
    for (int p = 0; p < 8; p++) begin
      if (p == 4) load_init(200);
      for (int k = 0; k < M; k++) begin
        case (p)
          0: ind[k] = k;
          1: ind[k] = 0;
          2: ind[k] = M - 1;
          3: ind[k] = M - 1 - k;
          4: ind[k] = (k < 2) ? 0 : (k < 5) ? 3 : (k < 7) ? 5 : 6;
          5: ind[k] = (k / 2) * 2 + 1 - ((k / 2) % 2);
          6: ind[k] = (k * k * 3 + 5) % M;
          default: ind[k] = (k * 5 + 3) % M;
        endcase
      end
      run_pass(p == 3);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule